// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one READ or WRITE command into the sequence of column addresses that the burst touches, one address per clock. The command supplies a start strobe, a read/write flag and a 9-bit start column. The controller's current mode settings supply the burst-length code, the burst order and the write single-access bit. From the cycle after the strobe, the block presents a valid flag, the column of the current beat and a flag that marks the final beat.

Every burst stays inside an aligned block of columns whose size equals the burst length. The high column bits choose the block and never change during the burst. The low bits start at the requested offset and then step through the block in either a counting order or an XOR order. When the count passes the block boundary it wraps back to the block's start. A fresh strobe on any cycle cuts the running burst short and starts the new one. Reserved length codes give a one-beat burst and raise an error flag.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held low and after it is released, beat_vld_o, last_o and bl_err_o are low until a start strobe is taken.
- R2: A strobe sampled on a rising edge makes beat 0 visible after that edge. The block then produces one beat per clock for exactly burst-length beats, and beat_vld_o falls after the final beat.
- R3: Burst-length code 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8.
- R4: With order_i = 0 (counting order), the low log2(L) column bits on beat k equal (start offset + k) mod L.
- R5: With order_i = 1 (XOR order), the low log2(L) column bits on beat k equal the start offset XOR k.
- R6: Column bits 8 down to log2(L) equal those of the start column on every beat of the burst.
- R7: last_o is high on the final beat of a burst and low on every other beat.
- R8: When wr_i = 1 and wr_single_i = 1, the burst is one beat at the start column. When wr_i = 0, wr_single_i has no effect on the length.
- R9: A reserved length code (3'b100 to 3'b111) gives a one-beat burst, and bl_err_o is high on that beat.
- R10: A strobe during a running burst ends it. The beat shown in the strobe's cycle is still the old burst's beat, and beat 0 of the new burst appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe for a new burst |
| wr_i | input | 1 | 1 for a write command, 0 for a read |
| start_col_i | input | 9 | Start column of the command |
| bl_code_i | input | 3 | Burst-length code |
| order_i | input | 1 | Burst order: 0 counting, 1 XOR |
| wr_single_i | input | 1 | 1 forces writes to a single location |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| col_o | output | 9 | Column address of the current beat |
| last_o | output | 1 | Current beat is the final one |
| bl_err_o | output | 1 | Current burst was launched with a reserved length code |

## Verification
On every cycle, the assertions check four things. A strobe leads to a valid beat at the requested column. The block-select bits hold still through a burst. The beat count never leaves its block. The valid flag drops after the final beat unless a new strobe arrives. They also check that the error flag only appears on a single-beat burst.

Only the bench's scenarios can show the full beat ordering, compared against an independent model for every offset, length and order. The same holds for:
- the exact burst lengths;
- the write single-access override and its lack of effect on reads;
- truncation timing;
- reserved-code handling.

// File: rtl/colgen_pkg.sv
`timescale 1ns/1ps
// colgen_pkg: shared types for the burst column generator.
// Assumes: one burst order bit as carried by the mode settings.
package colgen_pkg;
    typedef enum logic {
        ORD_COUNT = 1'b0,
        ORD_XOR   = 1'b1
    } burst_order_e;
endpackage

// File: rtl/colgen_mode_decode.sv
`timescale 1ns/1ps
// colgen_mode_decode: turns the burst-length code plus the command type
// into log2 of the effective burst length, and flags reserved codes.
// Assumes: codes 0..3 map to 1,2,4,8; anything else is reserved.
module colgen_mode_decode #(
    parameter int CODE_W = 3,
    parameter int LG_W   = 2
) (
    input  logic [CODE_W-1:0] bl_code_i,
    input  logic              wr_i,
    input  logic              wr_single_i,
    output logic [LG_W-1:0]   lg_o,
    output logic              err_o
);
    localparam int NUM_LEGAL = 4;

    // Purpose: choose log2 length; reserved codes and single writes give 0.
    always_comb begin
        lg_o  = '0;
        err_o = 1'b0;
        if (int'(bl_code_i) < NUM_LEGAL) begin
            lg_o = LG_W'(bl_code_i);
        end else begin
            err_o = 1'b1;
        end
        if (wr_i && wr_single_i) begin
            lg_o = '0;
        end
    end
endmodule

// File: rtl/colgen_beat_ctr.sv
`timescale 1ns/1ps
// colgen_beat_ctr: holds the burst's length and counts beats from 0.
// Produces the offset mask of the block and the final-beat flag.
// Assumes: load restarts the count on any cycle, even mid-burst.
module colgen_beat_ctr #(
    parameter int MAX_LOG = 3,
    parameter int LG_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [LG_W-1:0]    lg_i,
    output logic               active_o,
    output logic [MAX_LOG-1:0] k_o,
    output logic [MAX_LOG-1:0] mask_o,
    output logic               last_o
);
    logic [LG_W-1:0] lg_q;

    // Purpose: mask with the low lg_q bits set.
    always_comb begin
        for (int i = 0; i < MAX_LOG; i++) begin
            mask_o[i] = (i < int'(lg_q));
        end
    end

    assign last_o = active_o && (k_o == mask_o);

    // Purpose: load on strobe, advance each beat, stop after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            k_o      <= '0;
            lg_q     <= '0;
        end else if (load_i) begin
            active_o <= 1'b1;
            k_o      <= '0;
            lg_q     <= lg_i;
        end else if (active_o) begin
            if (last_o) begin
                active_o <= 1'b0;
            end else begin
                k_o <= k_o + 1'b1;
            end
        end
    end

    // R2: a final beat with no new strobe ends the burst.
    a_r2_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !load_i) |=> !active_o);

    // R3: the beat index never leaves the block.
    a_r3_k_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> ((k_o & ~mask_o) == '0));

    // R2: a burst that is not at its final beat keeps going.
    a_r2_keeps_going: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !last_o) |=> active_o);
endmodule

// File: rtl/colgen_addr_mix.sv
`timescale 1ns/1ps
// colgen_addr_mix: forms the beat's column from the start column, the
// beat index, the block mask and the burst order.
// Assumes: k_i < block size; the mask is a run of low ones.
module colgen_addr_mix
    import colgen_pkg::*;
#(
    parameter int COL_W   = 9,
    parameter int MAX_LOG = 3
) (
    input  logic [COL_W-1:0]   base_i,
    input  logic [MAX_LOG-1:0] k_i,
    input  logic [MAX_LOG-1:0] mask_i,
    input  burst_order_e       order_i,
    output logic [COL_W-1:0]   col_o
);
    logic [MAX_LOG-1:0] off;
    logic [MAX_LOG-1:0] low_cnt;
    logic [MAX_LOG-1:0] low_xor;
    logic [MAX_LOG-1:0] low_sel;

    // Purpose: compute both orders inside the block, then pick one.
    always_comb begin
        off     = base_i[MAX_LOG-1:0] & mask_i;
        low_cnt = (off + k_i) & mask_i;
        low_xor = (off ^ k_i) & mask_i;
        low_sel = (order_i == ORD_XOR) ? low_xor : low_cnt;
        col_o   = {base_i[COL_W-1:MAX_LOG],
                   (base_i[MAX_LOG-1:0] & ~mask_i) | low_sel};
    end
endmodule

// File: rtl/sdram_burst_colgen.sv
`timescale 1ns/1ps
// sdram_burst_colgen: column address for each beat of a READ/WRITE burst.
// Captures the command and mode fields on start_i and presents beat 0 on
// the next cycle, then one beat per clock.
// Assumes: mode inputs are valid in the cycle of start_i.
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W   = 9,
    parameter int CODE_W  = 3,
    parameter int MAX_LOG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              wr_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [CODE_W-1:0] bl_code_i,
    input  logic              order_i,
    input  logic              wr_single_i,
    output logic              beat_vld_o,
    output logic [COL_W-1:0]  col_o,
    output logic              last_o,
    output logic              bl_err_o
);
    localparam int LG_W = $clog2(MAX_LOG + 1);

    logic [LG_W-1:0]    dec_lg;
    logic               dec_err;
    logic [COL_W-1:0]   base_q;
    burst_order_e       order_q;
    logic               err_q;
    logic [MAX_LOG-1:0] beat_k;
    logic [MAX_LOG-1:0] blk_mask;

    colgen_mode_decode #(.CODE_W(CODE_W), .LG_W(LG_W)) u_dec (
        .bl_code_i  (bl_code_i),
        .wr_i       (wr_i),
        .wr_single_i(wr_single_i),
        .lg_o       (dec_lg),
        .err_o      (dec_err)
    );

    colgen_beat_ctr #(.MAX_LOG(MAX_LOG), .LG_W(LG_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start_i),
        .lg_i    (dec_lg),
        .active_o(beat_vld_o),
        .k_o     (beat_k),
        .mask_o  (blk_mask),
        .last_o  (last_o)
    );

    colgen_addr_mix #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) u_mix (
        .base_i (base_q),
        .k_i    (beat_k),
        .mask_i (blk_mask),
        .order_i(order_q),
        .col_o  (col_o)
    );

    // Purpose: capture the command column, order and error on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            order_q <= ORD_COUNT;
            err_q   <= 1'b0;
        end else if (start_i) begin
            base_q  <= start_col_i;
            order_q <= burst_order_e'(order_i);
            err_q   <= dec_err;
        end
    end

    assign bl_err_o = err_q && beat_vld_o;

    // R10: a strobe gives a valid beat at the requested column next cycle.
    a_r10_first_beat_col: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (beat_vld_o && col_o == $past(start_col_i)));

    // R6: block-select bits hold through a running burst.
    a_r6_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && !start_i) |=>
            (!beat_vld_o || col_o[COL_W-1:MAX_LOG] == $past(col_o[COL_W-1:MAX_LOG])));

    // R9: a reserved-code burst is a single beat.
    a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        bl_err_o |-> last_o);

    // R1: no beat is ever presented with the error flag outside a burst.
    a_r1_err_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_vld_o |-> (!bl_err_o && !last_o));
endmodule

// File: tb/sdram_burst_colgen_tb.sv
`timescale 1ns/1ps
module sdram_burst_colgen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] bl_code_i = '0;
    logic       order_i = 1'b0;
    logic       wr_single_i = 1'b0;
    logic       beat_vld_o;
    logic [8:0] col_o;
    logic       last_o;
    logic       bl_err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdram_burst_colgen u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_i(wr_i),
        .start_col_i(start_col_i), .bl_code_i(bl_code_i), .order_i(order_i),
        .wr_single_i(wr_single_i), .beat_vld_o(beat_vld_o), .col_o(col_o),
        .last_o(last_o), .bl_err_o(bl_err_o)
    );

    // vector: {wr, single, order, code[2:0], col[8:0]}
    localparam int NV = 10;
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 3'd3, 9'h1FD},
        {1'b0, 1'b0, 1'b1, 3'd3, 9'h0A6},
        {1'b0, 1'b1, 1'b0, 3'd3, 9'h033},
        {1'b1, 1'b1, 1'b0, 3'd3, 9'h033},
        {1'b1, 1'b0, 1'b1, 3'd2, 9'h107},
        {1'b0, 1'b0, 1'b0, 3'd1, 9'h0FF},
        {1'b0, 1'b0, 1'b1, 3'd5, 9'h12E},
        {1'b0, 1'b0, 1'b0, 3'd7, 9'h001},
        {1'b1, 1'b1, 1'b1, 3'd4, 9'h155},
        {1'b0, 1'b0, 1'b1, 3'd0, 9'h1FF}
    };

    function automatic int len_of(input logic [2:0] code, input logic wr, input logic single);
        if (wr && single) return 1;
        case (code)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic int ref_col(input int col, input int len, input logic ord, input int k);
        int off = col % len;
        int low = ord ? (off ^ k) : ((off + k) % len);
        return (col - off) + low;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Drive a strobe at a falling edge; return at the falling edge after it.
    task automatic launch(input logic wr, input logic single, input logic ord,
                          input logic [2:0] code, input logic [8:0] col);
        start_i = 1'b1; wr_i = wr; wr_single_i = single; order_i = ord;
        bl_code_i = code; start_col_i = col;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Check a whole burst beat by beat, then check that valid drops.
    task automatic run_burst(input logic wr, input logic single, input logic ord,
                             input logic [2:0] code, input logic [8:0] col);
        int len = len_of(code, wr, single);
        bit rsv = (code > 3'd3);
        launch(wr, single, ord, code, col);
        for (int k = 0; k < len; k++) begin
            int e = ref_col(int'(col), len, ord, k);
            chk(beat_vld_o === 1'b1, "R2 valid", int'(beat_vld_o), 1);
            chk(col_o === 9'(e), ord ? "R5/R6 xor col" : "R4/R6 count col", int'(col_o), e);
            chk(last_o === (k == len - 1), "R7 last", int'(last_o), int'(k == len - 1));
            chk(bl_err_o === rsv, "R9 err", int'(bl_err_o), int'(rsv));
            @(negedge clk);
        end
        chk(beat_vld_o === 1'b0, "R2/R3 length end", int'(beat_vld_o), 0);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(beat_vld_o === 1'b0 && last_o === 1'b0 && bl_err_o === 1'b0,
            "R1 in reset", int'({beat_vld_o, last_o, bl_err_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(beat_vld_o === 1'b0 && last_o === 1'b0 && bl_err_o === 1'b0,
            "R1 after reset", int'({beat_vld_o, last_o, bl_err_o}), 0);

        // Table walk (R8 single write vs read, R9 reserved codes).
        for (int v = 0; v < NV; v++) begin
            run_burst(VEC[v][14], VEC[v][13], VEC[v][12], VEC[v][11:9], VEC[v][8:0]);
        end

        // R3 R4 R5: every length, order and start offset.
        for (int c = 0; c < 4; c++)
            for (int o = 0; o < 2; o++)
                for (int off = 0; off < 8; off++)
                    run_burst(1'b0, 1'b0, o[0], c[2:0], 9'((c * 40 + o * 72) << 3) | 9'(off));

        // R10: truncate an 8-beat burst after three beats.
        launch(1'b0, 1'b0, 1'b0, 3'd3, 9'h046);
        @(negedge clk); @(negedge clk);
        start_i = 1'b1; bl_code_i = 3'd2; order_i = 1'b1; start_col_i = 9'h0F1;
        chk(col_o === 9'h040, "R10 old beat in strobe cycle", int'(col_o), 'h040);
        @(negedge clk);
        start_i = 1'b0;
        chk(beat_vld_o === 1'b1 && col_o === 9'h0F1, "R10 new beat0", int'(col_o), 'h0F1);
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            chk(col_o === 9'(ref_col('h0F1, 4, 1'b1, k)), "R10 new burst", int'(col_o),
                ref_col('h0F1, 4, 1'b1, k));
        end
        @(negedge clk);
        chk(beat_vld_o === 1'b0, "R10 new burst ends", int'(beat_vld_o), 0);

        // R1: reset in the middle of a burst clears outputs.
        launch(1'b0, 1'b0, 1'b0, 3'd6, 9'h010);
        launch(1'b0, 1'b0, 1'b0, 3'd3, 9'h010);
        rst_n = 1'b0;
        @(negedge clk);
        chk(beat_vld_o === 1'b0 && bl_err_o === 1'b0, "R1 mid-burst reset",
            int'(beat_vld_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(beat_vld_o === 1'b0, "R1 idle after reset", int'(beat_vld_o), 0);
        finish_run();
    end
endmodule